// File: doc/BRIEF.md
# Match and Capture Timer/Counter

A 32-bit timer/counter with a word-addressed register port. In timer mode the count advances once every (prescale + 1) enabled clocks. In counter mode the count advances on edges of one selected external input, and the prescaler is bypassed. Four match channels compare the count on every count event. On a match, each channel can raise its flag, return the count to zero or stop the timer. Each channel also drives an external match pin that can be held, cleared, set or toggled. Four capture channels synchronise their inputs, detect the selected edges and latch the count. They can also raise their own flags.

Software clears flags by writing one to them. The interrupt output is high whenever any flag is set. Writes take effect on the clock edge at which `we_i` is high. Reads are combinational from `addr_i`.

Register word addresses are: control 0, count mode 1, prescale 2, prescale count 3, count 4, flags 5, match control 6, capture control 7, external match 8, match value n at 16+n, and captured value n at 24+n. Unlisted addresses read as zero.

Top module: `mc_timer`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `em_o` is 0.
- R2: In timer mode (count mode bits 1:0 = 0) with control bit 0 set, the prescale count steps 0..P and wraps, where P is the prescale value. The count increments at each wrap, so after K enabled clocks the count is K/(P+1) and the prescale count is K mod (P+1).
- R3: Control bit 1 holds the count and the prescale count at zero while it is set. With control bit 0 clear, the count does not change.
- R4: A match event for channel n occurs on a count event while the count equals match value n. If match control bit 3n is set, flag bit n is set. If bit 3n+1 is set, the next count is 0, so the count cycles 0..M.
- R5: If match control bit 3n+2 is set, a match event clears control bit 0 and the count holds at the match value. Without bit 3n, no flag is raised.
- R6: Writing 1 to a flag bit clears it, and writing 0 has no effect. `irq_o` is the OR of all flags. If a flag is set and cleared in the same cycle, it stays set.
- R7: Capture control bit 3n selects capture on rising edges of input n, and bit 3n+1 selects falling edges. A capture latches the count into captured value n. Flag bit 4+n is set only if bit 3n+2 is set. Edges that are not selected leave the captured value and the flag unchanged.
- R8: Capture and count inputs pass through two synchronising flops. A change that is applied before clock edge E is acted on at edge E+2, and the latched count is the value the count held just before E+2.
- R9: Count mode bits 1:0 set to 1, 2 or 3 count rising, falling or both edges of the capture input selected by bits 3:2. The prescale value has no effect in these modes.
- R10: External match register bits 0..3 are the pin levels driven on `em_o`. The 2-bit field at bits 4+2n applies on a match of channel n: 0 keeps the level, 1 clears it, 2 sets it, 3 toggles it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| cap_i | input | 4 | Capture and count inputs, asynchronous |
| em_o | output | 4 | External match pin levels |
| irq_o | output | 1 | Interrupt, OR of all flags |

## Verification
The bench builds the block with its default parameters: a 32-bit count, four match channels and four capture channels. With these defaults every flag and control field sits at the bit position the requirements give. The bench can load small prescale and match values, which makes wrap, reset-on-match and stop reachable within a few dozen clocks. Because all four capture inputs are present, the bench can use one input as the count source while another checks capture edge selection and the exact synchroniser latency.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
  localparam int unsigned ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL  = 5'd0;
  localparam addr_t A_MODE  = 5'd1;
  localparam addr_t A_PRESC = 5'd2;
  localparam addr_t A_PCNT  = 5'd3;
  localparam addr_t A_COUNT = 5'd4;
  localparam addr_t A_FLAGS = 5'd5;
  localparam addr_t A_MCTL  = 5'd6;
  localparam addr_t A_CCTL  = 5'd7;
  localparam addr_t A_EXTM  = 5'd8;
  localparam int unsigned A_MATCH0 = 16;
  localparam int unsigned A_CAPT0  = 24;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_BOTH  = 2'd3
  } cnt_src_e;

  typedef enum logic [1:0] {
    EM_KEEP = 2'd0,
    EM_LOW  = 2'd1,
    EM_HIGH = 2'd2,
    EM_FLIP = 2'd3
  } em_act_e;
endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= sig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             timer_mode_i,
  input  logic             ext_edge_i,
  input  logic [CNT_W-1:0] presc_i,
  input  logic             cnt_we_i,
  input  logic             pcnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             mrst_i,
  input  logic             mstop_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pcnt_o
);
  logic [CNT_W-1:0] cnt_q, pcnt_q;
  logic             pwrap;

  // >= keeps the wrap safe if the prescale value is lowered below the running count
  assign pwrap  = (pcnt_q >= presc_i);
  assign tick_o = en_i && !clr_i && (timer_mode_i ? pwrap : ext_edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (cnt_we_i)      cnt_q <= wdata_i;
      else if (tick_o) begin
        if (mrst_i)        cnt_q <= '0;
        else if (!mstop_i) cnt_q <= cnt_q + 1'b1;
      end
      if (pcnt_we_i)                  pcnt_q <= wdata_i;
      else if (en_i && timer_mode_i)  pcnt_q <= pwrap ? '0 : pcnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign pcnt_o = pcnt_q;
endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit
  import mc_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 4,
  localparam int unsigned MCTL_W = 3 * N_MATCH,
  localparam int unsigned EXTM_W = 3 * N_MATCH
) (
  input  logic                            tick_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0]   match_i,
  input  logic [MCTL_W-1:0]               mctl_i,
  input  logic [EXTM_W-1:0]               extm_i,
  output logic [N_MATCH-1:0]              hit_o,
  output logic [N_MATCH-1:0]              irq_o,
  output logic                            mrst_o,
  output logic                            mstop_o,
  output logic [N_MATCH-1:0]              lvl_o
);
  logic [N_MATCH-1:0] rst_v, stop_v;

  for (genvar n = 0; n < N_MATCH; n++) begin : g_ch
    logic [1:0] act;
    logic       lvl;
    assign act       = extm_i[N_MATCH + 2*n +: 2];
    assign lvl       = extm_i[n];
    assign hit_o[n]  = tick_i && (cnt_i == match_i[n]);
    assign irq_o[n]  = hit_o[n] & mctl_i[3*n];
    assign rst_v[n]  = hit_o[n] & mctl_i[3*n+1];
    assign stop_v[n] = hit_o[n] & mctl_i[3*n+2];
    assign lvl_o[n]  = !hit_o[n]       ? lvl  :
                       (act == EM_LOW)  ? 1'b0 :
                       (act == EM_HIGH) ? 1'b1 :
                       (act == EM_FLIP) ? ~lvl : lvl;
  end

  assign mrst_o  = |rst_v;
  assign mstop_o = |stop_v;
endmodule

// File: rtl/mct_capture_unit.sv
module mct_capture_unit #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CAP  = 4,
  localparam int unsigned CCTL_W = 3 * N_CAP
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CAP-1:0]              rise_i,
  input  logic [N_CAP-1:0]              fall_i,
  input  logic [CCTL_W-1:0]             cctl_i,
  input  logic [CNT_W-1:0]              cnt_i,
  output logic [N_CAP-1:0]              ev_o,
  output logic [N_CAP-1:0]              irq_o,
  output logic [N_CAP-1:0][CNT_W-1:0]   capt_o
);
  logic [N_CAP-1:0][CNT_W-1:0] capt_q;

  for (genvar n = 0; n < N_CAP; n++) begin : g_ch
    assign ev_o[n]  = (rise_i[n] & cctl_i[3*n]) | (fall_i[n] & cctl_i[3*n+1]);
    assign irq_o[n] = ev_o[n] & cctl_i[3*n+2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capt_q <= '0;
    end else begin
      for (int n = 0; n < N_CAP; n++)
        if (ev_o[n]) capt_q[n] <= cnt_i;
    end
  end

  assign capt_o = capt_q;
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mc_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned N_CAP   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [N_CAP-1:0]   cap_i,
  output logic [N_MATCH-1:0] em_o,
  output logic               irq_o
);
  localparam int unsigned FLAG_W = N_MATCH + N_CAP;
  localparam int unsigned MCTL_W = 3 * N_MATCH;
  localparam int unsigned CCTL_W = 3 * N_CAP;
  localparam int unsigned EXTM_W = 3 * N_MATCH;

  logic                          en_q, clr_q;
  logic [3:0]                    mode_q;
  logic [CNT_W-1:0]              presc_q;
  logic [FLAG_W-1:0]             flags_q;
  logic [MCTL_W-1:0]             mctl_q;
  logic [CCTL_W-1:0]             cctl_q;
  logic [EXTM_W-1:0]             extm_q;
  logic [N_MATCH-1:0][CNT_W-1:0] match_q;

  logic [N_CAP-1:0]              cap_rise, cap_fall, cap_ev, cap_irq;
  logic [N_CAP-1:0][CNT_W-1:0]   capt_q;
  logic [N_MATCH-1:0]            m_hit, m_irq, m_lvl;
  logic                          m_rst, m_stop, tick;
  logic [CNT_W-1:0]              count, pcount;
  logic                          sel_rise, sel_fall, ext_edge, timer_mode;
  logic                          wr_ctrl, wr_flags;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_flags = we_i && (addr_i == A_FLAGS);

  mct_edge_sync #(.W(N_CAP)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cap_i),
    .rise_o (cap_rise),
    .fall_o (cap_fall)
  );

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    for (int i = 0; i < N_CAP; i++) begin
      if (mode_q[3:2] == 2'(i)) begin
        sel_rise = cap_rise[i];
        sel_fall = cap_fall[i];
      end
    end
  end

  assign timer_mode = (cnt_src_e'(mode_q[1:0]) == SRC_TIMER);

  always_comb begin
    case (cnt_src_e'(mode_q[1:0]))
      SRC_RISE: ext_edge = sel_rise;
      SRC_FALL: ext_edge = sel_fall;
      SRC_BOTH: ext_edge = sel_rise | sel_fall;
      default:  ext_edge = 1'b0;
    endcase
  end

  mct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .clr_i        (clr_q),
    .timer_mode_i (timer_mode),
    .ext_edge_i   (ext_edge),
    .presc_i      (presc_q),
    .cnt_we_i     (we_i && (addr_i == A_COUNT)),
    .pcnt_we_i    (we_i && (addr_i == A_PCNT)),
    .wdata_i      (wdata_i),
    .mrst_i       (m_rst),
    .mstop_i      (m_stop),
    .tick_o       (tick),
    .cnt_o        (count),
    .pcnt_o       (pcount)
  );

  mct_match_unit #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
    .tick_i  (tick),
    .cnt_i   (count),
    .match_i (match_q),
    .mctl_i  (mctl_q),
    .extm_i  (extm_q),
    .hit_o   (m_hit),
    .irq_o   (m_irq),
    .mrst_o  (m_rst),
    .mstop_o (m_stop),
    .lvl_o   (m_lvl)
  );

  mct_capture_unit #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_capt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (cap_rise),
    .fall_i (cap_fall),
    .cctl_i (cctl_q),
    .cnt_i  (count),
    .ev_o   (cap_ev),
    .irq_o  (cap_irq),
    .capt_o (capt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      mode_q  <= '0;
      presc_q <= '0;
      flags_q <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      extm_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[0];
        clr_q <= wdata_i[1];
      end
      if (m_stop) en_q <= 1'b0;  // stop beats a same-cycle enable write
      if (we_i && addr_i == A_MODE)  mode_q  <= wdata_i[3:0];
      if (we_i && addr_i == A_PRESC) presc_q <= wdata_i;
      if (we_i && addr_i == A_MCTL)  mctl_q  <= wdata_i[MCTL_W-1:0];
      if (we_i && addr_i == A_CCTL)  cctl_q  <= wdata_i[CCTL_W-1:0];
      if (we_i && addr_i == A_EXTM)  extm_q  <= wdata_i[EXTM_W-1:0];
      else                           extm_q[N_MATCH-1:0] <= m_lvl;
      for (int n = 0; n < N_MATCH; n++)
        if (we_i && addr_i == addr_t'(A_MATCH0 + n)) match_q[n] <= wdata_i;
      // set wins over write-one-to-clear
      flags_q <= (flags_q & ~(wr_flags ? wdata_i[FLAG_W-1:0] : '0)) | {cap_irq, m_irq};
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[1:0]        = {clr_q, en_q};
      A_MODE:  rdata_o[3:0]        = mode_q;
      A_PRESC: rdata_o             = presc_q;
      A_PCNT:  rdata_o             = pcount;
      A_COUNT: rdata_o             = count;
      A_FLAGS: rdata_o[FLAG_W-1:0] = flags_q;
      A_MCTL:  rdata_o[MCTL_W-1:0] = mctl_q;
      A_CCTL:  rdata_o[CCTL_W-1:0] = cctl_q;
      A_EXTM:  rdata_o[EXTM_W-1:0] = extm_q;
      default: begin
        for (int n = 0; n < N_MATCH; n++)
          if (addr_i == addr_t'(A_MATCH0 + n)) rdata_o = match_q[n];
        for (int n = 0; n < N_CAP; n++)
          if (addr_i == addr_t'(A_CAPT0 + n)) rdata_o = capt_q[n];
      end
    endcase
  end

  assign em_o  = extm_q[N_MATCH-1:0];
  assign irq_o = |flags_q;
endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk
  import mc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CAP  = 4,
  parameter int unsigned FLAG_W = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        en_i,
  input logic                        clr_i,
  input logic [CNT_W-1:0]            cnt_i,
  input logic [FLAG_W-1:0]           flags_i,
  input logic                        mrst_i,
  input logic                        mstop_i,
  input logic [N_CAP-1:0]            cap_ev_i,
  input logic [N_CAP-1:0][CNT_W-1:0] capt_i
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = we_i && (addr_i == A_COUNT);
  assign flag_wr = we_i && (addr_i == A_FLAGS);

  AST_CLR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == '0)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && !cnt_wr) |=> $stable(cnt_i)); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !cnt_wr) |=> ((cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == '0) || $stable(cnt_i))); // R2
  AST_MATCH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && !cnt_wr) |=> (cnt_i == '0)); // R4
  AST_STOP_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstop_i |=> !en_i); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> ((flags_i & $past(flags_i)) == $past(flags_i))); // R6

  for (genvar n = 0; n < N_CAP; n++) begin : g_cap
    AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_ev_i[n] |=> (capt_i[n] == $past(cnt_i))); // R7
  end
endmodule

bind mc_timer mc_timer_chk #(.CNT_W(CNT_W), .N_CAP(N_CAP), .FLAG_W(N_MATCH + N_CAP)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .en_i     (en_q),
  .clr_i    (clr_q),
  .cnt_i    (count),
  .flags_i  (flags_q),
  .mrst_i   (m_rst),
  .mstop_i  (m_stop),
  .cap_ev_i (cap_ev),
  .capt_i   (capt_q)
);

// File: tb/tb_mc_timer.sv
`timescale 1ns/1ps
module tb_mc_timer;
  localparam logic [4:0] A_CTRL = 5'd0, A_MODE = 5'd1, A_PRESC = 5'd2, A_PCNT = 5'd3,
                         A_COUNT = 5'd4, A_FLAGS = 5'd5, A_MCTL = 5'd6, A_CCTL = 5'd7,
                         A_EXTM = 5'd8, A_MATCH0 = 5'd16, A_CAPT0 = 5'd24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic [3:0]  em;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  mc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .em_o(em), .irq_o(irq)
  );

  function automatic logic [31:0] f_presc_cnt(int k, int p);
    return 32'(k / (p + 1));
  endfunction
  function automatic logic [31:0] f_presc_pc(int k, int p);
    return 32'(k % (p + 1));
  endfunction
  function automatic logic [31:0] f_match_cnt(int k, int m);
    return 32'(k % (m + 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      cap[idx] = 1'b1; idle(3);
      cap[idx] = 1'b0; idle(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, v3;
    void'($urandom(32'd1577));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_COUNT, v); chk("R1 count", v, 0);
    rd(A_FLAGS, v); chk("R1 flags", v, 0);
    rd(A_PRESC, v); chk("R1 presc", v, 0);
    rd(A_EXTM, v);  chk("R1 extm", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 em", 32'(em), 0);

    // R2 random prescale runs
    for (int it = 0; it < 6; it++) begin
      int p, k;
      p = int'($urandom_range(0, 7));
      k = int'($urandom_range(1, 60));
      wr(A_PRESC, 32'(p)); wr(A_COUNT, 0); wr(A_PCNT, 0);
      wr(A_CTRL, 1); idle(k - 1); wr(A_CTRL, 0);
      rd(A_COUNT, v); chk("R2 count", v, f_presc_cnt(k, p));
      rd(A_PCNT, v);  chk("R2 pcount", v, f_presc_pc(k, p));
    end

    // R3 frozen while disabled, reset bit holds zero
    rd(A_COUNT, v2); idle(5);
    rd(A_COUNT, v); chk("R3 frozen", v, v2);
    wr(A_PRESC, 0); wr(A_COUNT, 77); wr(A_PCNT, 3);
    wr(A_CTRL, 3); idle(3);
    rd(A_COUNT, v); chk("R3 held count", v, 0);
    rd(A_PCNT, v);  chk("R3 held pcount", v, 0);
    wr(A_CTRL, 1); idle(2); wr(A_CTRL, 0);
    rd(A_COUNT, v); chk("R3 resume", v, 3);

    // R4 random reset-on-match with interrupt
    for (int it = 0; it < 5; it++) begin
      int m, k;
      m = int'($urandom_range(1, 10));
      k = int'($urandom_range(1, 40));
      wr(A_MCTL, 32'h3); wr(A_MATCH0, 32'(m)); wr(A_FLAGS, 32'hff); wr(A_COUNT, 0);
      wr(A_CTRL, 1); idle(k - 1); wr(A_CTRL, 0);
      rd(A_COUNT, v); chk("R4 count", v, f_match_cnt(k, m));
      rd(A_FLAGS, v); chk("R4 flag", v, (k > m) ? 32'h1 : 32'h0);
    end

    // R6 write-one-to-clear and set priority
    wr(A_MATCH0, 3); wr(A_COUNT, 0); wr(A_CTRL, 1); idle(9); wr(A_CTRL, 0);
    wr(A_FLAGS, 0);
    rd(A_FLAGS, v); chk("R6 zero write", v, 1);
    chk("R6 irq high", 32'(irq), 1);
    wr(A_FLAGS, 1);
    rd(A_FLAGS, v); chk("R6 cleared", v, 0);
    chk("R6 irq low", 32'(irq), 0);
    wr(A_MATCH0, 5); wr(A_COUNT, 0); wr(A_CTRL, 1); idle(5);
    wr(A_FLAGS, 1);  // lands on the match edge
    rd(A_FLAGS, v); chk("R6 set wins", v, 1);
    wr(A_CTRL, 0); wr(A_FLAGS, 32'hff);

    // R5 stop on match
    wr(A_MCTL, 32'h20); wr(A_MATCH0 + 5'd1, 7); wr(A_COUNT, 0);
    wr(A_CTRL, 1); idle(12);
    rd(A_CTRL, v);  chk("R5 enable cleared", v, 0);
    rd(A_COUNT, v); chk("R5 held at match", v, 7);
    rd(A_FLAGS, v); chk("R5 no flag", v, 0);
    wr(A_MCTL, 0);

    // R8 capture latency while counting
    wr(A_CCTL, 32'h1); wr(A_COUNT, 0); wr(A_CTRL, 1);
    cap[0] = 1'b1;
    idle(4); wr(A_CTRL, 0);
    rd(A_CAPT0, v); chk("R8 latched count", v, 2);
    rd(A_FLAGS, v); chk("R7 no capture flag", v, 0);

    // R7 edge selection and flag enable
    v2 = $urandom;
    wr(A_CCTL, 32'h140); wr(A_COUNT, v2);
    cap[2] = 1'b1; idle(4);
    rd(A_CAPT0 + 5'd2, v); chk("R7 rise capture", v, v2);
    rd(A_FLAGS, v); chk("R7 capture flag", v, 32'h40);
    wr(A_FLAGS, 32'hff);
    wr(A_COUNT, v2 + 32'd9);
    cap[2] = 1'b0; idle(4);
    rd(A_CAPT0 + 5'd2, v); chk("R7 fall ignored", v, v2);
    rd(A_FLAGS, v); chk("R7 fall no flag", v, 0);
    wr(A_CCTL, 32'h400);
    cap[3] = 1'b1; idle(4);
    v3 = $urandom;
    wr(A_COUNT, v3);
    cap[3] = 1'b0; idle(4);
    rd(A_CAPT0 + 5'd3, v); chk("R7 fall capture", v, v3);
    rd(A_FLAGS, v); chk("R7 fall no int", v, 0);
    wr(A_CCTL, 0);

    // R9 edge counting on input 1, prescale ignored
    wr(A_PRESC, 5); wr(A_COUNT, 0); wr(A_MODE, 32'h5); wr(A_CTRL, 1);
    pulses(1, 5); idle(3); wr(A_CTRL, 0);
    rd(A_COUNT, v); chk("R9 rising", v, 5);
    wr(A_COUNT, 0); wr(A_MODE, 32'h7); wr(A_CTRL, 1);
    pulses(1, 5); idle(3); wr(A_CTRL, 0);
    rd(A_COUNT, v); chk("R9 both", v, 10);
    wr(A_COUNT, 0); wr(A_MODE, 32'h6); wr(A_CTRL, 1);
    pulses(1, 4); idle(3); wr(A_CTRL, 0);
    rd(A_COUNT, v); chk("R9 falling", v, 4);
    wr(A_MODE, 0); wr(A_PRESC, 0);

    // R10 external match actions
    wr(A_MATCH0, 2); wr(A_MATCH0 + 5'd1, 3); wr(A_MATCH0 + 5'd2, 4); wr(A_MATCH0 + 5'd3, 1);
    wr(A_EXTM, 32'h1BC); wr(A_COUNT, 0);
    wr(A_CTRL, 1); idle(5); wr(A_CTRL, 0);
    chk("R10 pins", 32'(em), 32'hB);
    rd(A_EXTM, v); chk("R10 register", v, 32'h1BB);
    rd(A_COUNT, v); chk("R10 count", v, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule